// File: doc/BRIEF.md
# Transmit-Threshold Interrupt Controller for a FIFO-Buffered Serial Port

This block holds the control register of a serial port whose transmitter is fed from a small FIFO. It also produces the transmit-side interrupt. The register holds five enables: transmitter, receiver, transmit interrupt, receive interrupt and receive-error interrupt. It also holds a two-bit clock-source select. The block keeps a count of the bytes in the transmit FIFO. Software loads bytes with a push strobe, and the shifter takes them with a pop strobe.

When the shifter takes a byte and the count left behind is under a selectable trigger level, the block raises a "transmit room available" flag. The interrupt request is a registered copy of that flag, gated by the transmit interrupt enable. Software clears the flag in two steps. It must first read the flag as 1, then write 0 to it. The write takes effect only if the FIFO has meanwhile been refilled above the trigger level. A late or premature acknowledge therefore cannot hide a FIFO that still needs data.

Top module: `sfifo_txint_ctrl`

## Requirements
- R1: A synchronous reset sets the control register to 0x0000, the FIFO count to 0, the room flag to 0 and the interrupt request to 0.
- R2: A control write stores bits 7..3 and 1..0: 7 is the transmit IRQ enable, 6 the receive IRQ enable, 5 the transmitter enable, 4 the receiver enable, 3 the error IRQ enable, 1..0 the clock select. Bits 15..8 and bit 2 always read 0.
- R3: An accepted push adds one to the count and an accepted pop subtracts one. A push and a pop together leave the count unchanged. A pop at count 0 is ignored. A push at count 16 is dropped unless a pop is accepted in the same cycle. The count never exceeds 16.
- R4: The room flag is set in the cycle after an accepted pop whose resulting count is below the trigger level. The trigger select maps 0 to 8, 1 to 4, 2 to 2 and 3 to 0, so select 3 never sets the flag.
- R5: A flag write of 0 clears the flag if the flag was read as 1 since the last flag write and the count is above the trigger level in the write cycle. The flag reads 0 from the next cycle.
- R6: A flag write of 0 without a qualifying earlier read, or while the count is at or below the trigger level, leaves the flag set. Every flag write consumes the earlier read.
- R7: Writing 1 to the flag never changes it.
- R8: The interrupt request equals the AND of the transmit IRQ enable and the room flag, registered one clock later. Clearing the enable drops the request one cycle after the write and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register contents |
| sts_rd | input | 1 | Flag read strobe (arms the clear) |
| sts_wr | input | 1 | Flag write strobe |
| sts_wbit | input | 1 | Value written to the flag |
| sts_empty | output | 1 | Transmit room flag |
| fifo_push | input | 1 | Byte written into the transmit FIFO |
| fifo_pop | input | 1 | Byte taken by the shifter |
| trig_sel | input | 2 | Trigger level select |
| fifo_count | output | 5 | Bytes held in the transmit FIFO |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The control register, FIFO count and room flag are registered. Each reflects a stimulus at the first rising edge after the stimulus is driven. The interrupt request has one more register in its path, so it lags the flag or the enable by a further edge. The bench drives every vector on a falling edge and lets one rising edge pass. It samples at the following falling edge. Each vector's expected interrupt value is the enable AND flag left by the previous vector, and the enable-clear test looks at the request over two consecutive samples.

// File: rtl/sfifo_txint_pkg.sv
package sfifo_txint_pkg;

  // Bit positions of the control register fields (software decodes them)
  localparam int B_TIE  = 7;
  localparam int B_RIE  = 6;
  localparam int B_TE   = 5;
  localparam int B_RE   = 4;
  localparam int B_REIE = 3;

  typedef struct packed {
    logic       tie;
    logic       rie;
    logic       te;
    logic       re;
    logic       reie;
    logic       zero2;
    logic [1:0] cks;
  } ctl_low_t;

  // Trigger level: select 0..3 -> depth/2, depth/4, depth/8, 0
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    trig_level = depth / 2;
      2'd1:    trig_level = depth / 4;
      2'd2:    trig_level = depth / 8;
      default: trig_level = 0;
    endcase
  endfunction

endpackage

// File: rtl/sfifo_txint_ctl.sv
module sfifo_txint_ctl #(
  parameter int REGW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [REGW-1:0] wdata,
  output logic [REGW-1:0] rdata
);
  import sfifo_txint_pkg::*;

  localparam int HIW = REGW - 8;

  ctl_low_t low_q;
  ctl_low_t low_d;

  always_comb begin
    low_d       = ctl_low_t'(wdata[7:0]);
    low_d.zero2 = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)     low_q <= '0;
    else if (we) low_q <= low_d;
  end

  generate
    if (HIW > 0) begin : g_hi
      assign rdata = {{HIW{1'b0}}, low_q};
    end else begin : g_nohi
      assign rdata = low_q;
    end
  endgenerate

endmodule

// File: rtl/sfifo_txint_level.sv
module sfifo_txint_level #(
  parameter int DEPTH = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  output logic            pop_ok,
  output logic [CNTW-1:0] count_q,
  output logic [CNTW-1:0] count_nxt
);
  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  logic push_ok;

  always_comb begin
    pop_ok  = pop && (count_q != '0);
    push_ok = push && ((count_q != FULL) || pop_ok);
    case ({push_ok, pop_ok})
      2'b10:   count_nxt = count_q + 1'b1;
      2'b01:   count_nxt = count_q - 1'b1;
      default: count_nxt = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_nxt;
  end

endmodule

// File: rtl/sfifo_txint_flag.sv
module sfifo_txint_flag #(
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pop_ok,
  input  logic [CNTW-1:0] count_q,
  input  logic [CNTW-1:0] count_nxt,
  input  logic [CNTW-1:0] trig,
  input  logic            rd,
  input  logic            wr,
  input  logic            wbit,
  output logic            flag_q
);
  logic armed_q;
  logic set_c;
  logic clr_c;

  always_comb begin
    set_c = pop_ok && (count_nxt < trig);
    clr_c = wr && !wbit && armed_q && (count_q > trig);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_c)      flag_q <= 1'b1;
      else if (clr_c) flag_q <= 1'b0;
      if (wr)                armed_q <= 1'b0;
      else if (rd && flag_q) armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sfifo_txint_ctrl.sv
module sfifo_txint_ctrl #(
  parameter int DEPTH = 16,
  parameter int REGW  = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_we,
  input  logic [REGW-1:0] ctl_wdata,
  output logic [REGW-1:0] ctl_rdata,
  input  logic            sts_rd,
  input  logic            sts_wr,
  input  logic            sts_wbit,
  output logic            sts_empty,
  input  logic            fifo_push,
  input  logic            fifo_pop,
  input  logic [1:0]      trig_sel,
  output logic [CNTW-1:0] fifo_count,
  output logic            tx_irq
);
  import sfifo_txint_pkg::*;

  logic            pop_ok;
  logic [CNTW-1:0] count_nxt;
  logic [CNTW-1:0] trig;

  assign trig = CNTW'(trig_level(trig_sel, DEPTH));

  sfifo_txint_ctl #(.REGW(REGW)) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .rdata (ctl_rdata)
  );

  sfifo_txint_level #(.DEPTH(DEPTH)) u_level (
    .clk       (clk),
    .rst       (rst),
    .push      (fifo_push),
    .pop       (fifo_pop),
    .pop_ok    (pop_ok),
    .count_q   (fifo_count),
    .count_nxt (count_nxt)
  );

  sfifo_txint_flag #(.CNTW(CNTW)) u_flag (
    .clk       (clk),
    .rst       (rst),
    .pop_ok    (pop_ok),
    .count_q   (fifo_count),
    .count_nxt (count_nxt),
    .trig      (trig),
    .rd        (sts_rd),
    .wr        (sts_wr),
    .wbit      (sts_wbit),
    .flag_q    (sts_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_irq <= 1'b0;
    else     tx_irq <= ctl_rdata[B_TIE] & sts_empty;
  end

endmodule

// File: rtl/sfifo_txint_chk.sv
module sfifo_txint_chk #(
  parameter int DEPTH = 16,
  parameter int REGW  = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic [REGW-1:0] ctl_rdata,
  input logic            sts_wr,
  input logic            sts_wbit,
  input logic            sts_empty,
  input logic            fifo_push,
  input logic            fifo_pop,
  input logic [1:0]      trig_sel,
  input logic [CNTW-1:0] fifo_count,
  input logic            tx_irq
);
  import sfifo_txint_pkg::*;

  logic [CNTW-1:0] trig;
  logic            past_ok;

  assign trig = CNTW'(trig_level(trig_sel, DEPTH));

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[REGW-1:8] == '0) && (ctl_rdata[2] == 1'b0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNTW'(DEPTH));

  p_pair_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_push && fifo_pop && fifo_count != '0) |=> $stable(fifo_count));

  p_set_on_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop && !fifo_push && fifo_count != '0 && (fifo_count - 1'b1) < trig) |=> sts_empty);

  p_hold_low_r6: assert property (@(posedge clk) disable iff (rst)
    (sts_empty && sts_wr && fifo_count <= trig) |=> sts_empty);

  p_write1_r7: assert property (@(posedge clk) disable iff (rst)
    (sts_empty && sts_wr && sts_wbit) |=> sts_empty);

  p_irq_lag_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (tx_irq == ($past(ctl_rdata[B_TIE]) && $past(sts_empty))));

endmodule

bind sfifo_txint_ctrl sfifo_txint_chk #(.DEPTH(DEPTH), .REGW(REGW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_rdata  (ctl_rdata),
  .sts_wr     (sts_wr),
  .sts_wbit   (sts_wbit),
  .sts_empty  (sts_empty),
  .fifo_push  (fifo_push),
  .fifo_pop   (fifo_pop),
  .trig_sel   (trig_sel),
  .fifo_count (fifo_count),
  .tx_irq     (tx_irq)
);

// File: tb/sfifo_txint_ctrl_test.sv
module sfifo_txint_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        sts_rd = 1'b0, sts_wr = 1'b0, sts_wbit = 1'b0;
  logic        sts_empty;
  logic        fifo_push = 1'b0, fifo_pop = 1'b0;
  logic [1:0]  trig_sel = 2'd1;
  logic [4:0]  fifo_count;
  logic        tx_irq;

  int applied = 0;
  int miscomp = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sfifo_txint_ctrl uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sts_rd(sts_rd), .sts_wr(sts_wr), .sts_wbit(sts_wbit), .sts_empty(sts_empty),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .trig_sel(trig_sel),
    .fifo_count(fifo_count), .tx_irq(tx_irq)
  );

  typedef struct packed {
    logic        pu, po, cwe;
    logic [15:0] cd;
    logic        rd, wr, wb;
    logic [4:0]  cnt;
    logic        flg, irq;
  } vec_t;

  // trigger select 1 (level 4) throughout the table
  localparam vec_t TBL [20] = '{
    '{1'b0,1'b0,1'b1,16'hFFFF,1'b0,1'b0,1'b0,5'd0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,16'h0,1'b0,1'b0,1'b0,5'd1,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,16'h0,1'b0,1'b0,1'b0,5'd2,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,16'h0,1'b0,1'b0,1'b0,5'd3,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,16'h0,1'b0,1'b0,1'b0,5'd4,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,16'h0,1'b0,1'b0,1'b0,5'd5,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,16'h0,1'b0,1'b0,1'b0,5'd4,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,16'h0,1'b0,1'b0,1'b0,5'd3,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,16'h0,1'b0,1'b0,1'b0,5'd3,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,16'h0,1'b0,1'b1,1'b0,5'd3,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,16'h0,1'b1,1'b0,1'b0,5'd3,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,16'h0,1'b0,1'b1,1'b0,5'd3,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,16'h0,1'b0,1'b0,1'b0,5'd4,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,16'h0,1'b0,1'b0,1'b0,5'd5,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,16'h0,1'b0,1'b1,1'b0,5'd5,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,16'h0,1'b1,1'b0,1'b0,5'd5,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,16'h0,1'b0,1'b1,1'b1,5'd5,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,16'h0,1'b1,1'b0,1'b0,5'd5,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,16'h0,1'b0,1'b1,1'b0,5'd5,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,16'h0,1'b0,1'b0,1'b0,5'd5,1'b0,1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic pu, po, cwe, input logic [15:0] cd,
                      input logic rd, wr, wb);
    fifo_push = pu; fifo_pop = po; ctl_we = cwe; ctl_wdata = cd;
    sts_rd = rd; sts_wr = wr; sts_wbit = wb;
    @(posedge clk);
    @(negedge clk);
    fifo_push = 0; fifo_pop = 0; ctl_we = 0; ctl_wdata = '0;
    sts_rd = 0; sts_wr = 0; sts_wbit = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0,0,0,16'h0,0,0,0);
    step(0,0,0,16'h0,0,0,0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 ctl", ctl_rdata, 0);
    check("R1 count", fifo_count, 0);
    check("R1 flag", sts_empty, 0);
    check("R1 irq", tx_irq, 0);

    // table walk, trigger level 4
    trig_sel = 2'd1;
    for (int i = 0; i < 20; i++) begin
      step(TBL[i].pu, TBL[i].po, TBL[i].cwe, TBL[i].cd, TBL[i].rd, TBL[i].wr, TBL[i].wb);
      check($sformatf("R3 count v%0d", i), fifo_count, TBL[i].cnt);
      check($sformatf("R4/R5/R6/R7 flag v%0d", i), sts_empty, TBL[i].flg);
      check($sformatf("R8 irq v%0d", i), tx_irq, TBL[i].irq);
    end
    // R2 masked fields after writing all ones
    check("R2 ctl readback", ctl_rdata, 16'h00FB);

    // R8 clearing the enable drops the request, keeps the flag
    step(0,1,0,16'h0,0,0,0);
    step(0,1,0,16'h0,0,0,0);
    step(0,0,0,16'h0,0,0,0);
    check("R8 irq before", tx_irq, 1);
    step(0,0,1,16'h0000,0,0,0);
    check("R8 irq lag", tx_irq, 1);
    check("R8 flag kept", sts_empty, 1);
    step(0,0,0,16'h0,0,0,0);
    check("R8 irq off", tx_irq, 0);
    check("R8 flag still", sts_empty, 1);
    check("R2 ctl cleared", ctl_rdata, 0);

    // R2 individual field pattern
    step(0,0,1,16'hA5A6,0,0,0);
    check("R2 pattern", ctl_rdata, 16'h00A2);

    // R3 overflow, pair at full, underflow, pair at empty
    do_reset();
    for (int i = 0; i < 20; i++) step(1,0,0,16'h0,0,0,0);
    check("R3 full cap", fifo_count, 16);
    step(1,1,0,16'h0,0,0,0);
    check("R3 pair at full", fifo_count, 16);
    for (int i = 0; i < 17; i++) step(0,1,0,16'h0,0,0,0);
    check("R3 pop empty ignored", fifo_count, 0);
    step(1,1,0,16'h0,0,0,0);
    check("R3 pair at empty", fifo_count, 1);

    // R4 trigger select 0 -> 8
    do_reset();
    trig_sel = 2'd0;
    for (int i = 0; i < 9; i++) step(1,0,0,16'h0,0,0,0);
    step(0,1,0,16'h0,0,0,0);
    check("R4 sel0 at 8", sts_empty, 0);
    step(0,1,0,16'h0,0,0,0);
    check("R4 sel0 at 7", sts_empty, 1);

    // R4 trigger select 2 -> 2
    do_reset();
    trig_sel = 2'd2;
    for (int i = 0; i < 3; i++) step(1,0,0,16'h0,0,0,0);
    step(0,1,0,16'h0,0,0,0);
    check("R4 sel2 at 2", sts_empty, 0);
    step(0,1,0,16'h0,0,0,0);
    check("R4 sel2 at 1", sts_empty, 1);

    // R4 trigger select 3 -> 0, never sets
    do_reset();
    trig_sel = 2'd3;
    step(1,0,0,16'h0,0,0,0);
    step(1,0,0,16'h0,0,0,0);
    step(0,1,0,16'h0,0,0,0);
    step(0,1,0,16'h0,0,0,0);
    check("R4 sel3 empty", sts_empty, 0);
    check("R4 sel3 count", fifo_count, 0);

    finish_run();
  end

endmodule